// File: doc/BRIEF.md
# Program Memory Table Access Unit

This unit lets a 16-bit data path read and write a program memory whose words are 24 bits wide. The data path sees each program word as two 16-bit spaces that sit side by side. The low space holds program bits 15:0. The high space holds program bits 23:16 in its lower byte, and its upper byte is a phantom byte that always reads as zero. A requester supplies an operation code, a byte/word flag, a 16-bit effective address and write data. The unit forms the full program address from an 8-bit page register and the effective address. It then drives a synchronous single-port memory interface, selects and zero-fills the byte lanes, and returns a 16-bit result.

The top bit of the page register chooses between user memory and configuration memory. Configuration memory can only be read, and only inside its implemented window. Any write there, and any read outside that window, is refused. A refused access never reaches the memory port and finishes with an error pulse and zero data. Each access uses a valid/ready handshake. The result appears exactly two cycles after acceptance: one cycle for the memory read and one for the registered result.

Top module: `pgm_table_access`

## Requirements
- R1: For an accepted access, `memCfg` equals page bit 7. `memAddr` equals page bits 6:0 followed by effective address bits 15:1. Effective address bit 0 is the byte select.
- R2: Operation code 0 (read low) in word mode returns program bits 15:0 on `rspRdata[15:0]`.
- R3: Operation code 0 in byte mode returns program bits 15:8 if the byte select is 1, or bits 7:0 if it is 0. The selected byte is placed in `rspRdata[7:0]`, and `rspRdata[15:8]` is zero.
- R4: Operation code 1 (read high) in word mode returns program bits 23:16 in `rspRdata[7:0]`, with `rspRdata[15:8]` zero.
- R5: Operation code 1 in byte mode returns program bits 23:16 in `rspRdata[7:0]` if the byte select is 0. It returns all zeros if the byte select is 1.
- R6: Operation code 2 (write low) in word mode writes lanes 1:0 (`memWmask` 3'b011) with `reqWdata`. In byte mode it writes only lane 1 (byte select 1) or only lane 0 (byte select 0), using `reqWdata[7:0]`.
- R7: Operation code 3 (write high) writes only lane 2 (`memWmask` 3'b100) with `reqWdata[7:0]`, in word mode and in byte mode with byte select 0. In byte mode with byte select 1 it updates no lane.
- R8: A write while page bit 7 is 1 is refused. The memory port stays idle, the stored word is unchanged, and the response carries `rspErr` = 1 and zero data.
- R9: A configuration read is issued only if its word address is below `CFG_IMPL_WORDS` (default 64). Otherwise it returns zero data with `rspErr` high for that single response cycle.
- R10: `reqReady` is high only while idle. `memEn` pulses only in the accept cycle. `rspValid` is high for exactly one cycle, two cycles after acceptance.
- R11: The page register resets to 0, so the first access after reset targets user memory. It is loaded from `pageWdata` when `pageWe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pageWe | input | 1 | Page register load strobe |
| pageWdata | input | 8 | New page register value |
| reqValid | input | 1 | Access request valid |
| reqReady | output | 1 | Unit idle, request accepted when valid |
| reqOp | input | 2 | 0 read low, 1 read high, 2 write low, 3 write high |
| reqByte | input | 1 | 1 byte mode, 0 word mode |
| reqAddr | input | 16 | Effective address, bit 0 is the byte select |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | Response valid, one cycle |
| rspRdata | output | 16 | Read result, zero for writes and errors |
| rspErr | output | 1 | Access refused |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write strobe |
| memCfg | output | 1 | 1 configuration region, 0 user region |
| memAddr | output | 22 | Program word address within the region |
| memWmask | output | 3 | Byte lane write enables, lane 2 is bits 23:16 |
| memWdata | output | 24 | Write data placed in lanes |
| memRdata | input | 24 | Read word, valid one cycle after a read strobe |

## Verification
The assertions assume a memory that returns read data one cycle after a read strobe. They also assume the requester holds `reqValid` and its fields steady until `reqReady` accepts them, and does not load the page register in the same cycle as an accepted request. The bench drives inputs just after the rising edge. It issues one request at a time, waits for the response before the next, and changes the page only between accesses. Random pages are drawn from both regions, including addresses just inside and outside the implemented configuration window, so refusal and lane paths are reached often.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;
  localparam int WORD_W = 3 * LANE_W;
  localparam int LANES  = WORD_W / LANE_W;

  typedef enum logic [1:0] {
    OP_RD_LO = 2'd0,
    OP_RD_HI = 2'd1,
    OP_WR_LO = 2'd2,
    OP_WR_HI = 2'd3
  } tblOp_e;

  typedef struct packed {
    logic latch;
    logic capture;
    logic zeroData;
  } tblStrobe_t;
endpackage

// File: rtl/pta_ctrl.sv
module pta_ctrl
  import pta_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       isWrite,
  input  logic       isCfg,
  input  logic       cfgImpl,
  output logic       reqReady,
  output logic       memEn,
  output logic       memWe,
  output tblStrobe_t strobe,
  output logic       rspValid,
  output logic       rspErr
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} ctrlState_e;

  ctrlState_e stateQ, stateD;
  logic errQ, noDataQ;
  logic accept, refuse;

  assign reqReady = (stateQ == ST_IDLE);
  assign accept   = reqValid & reqReady;
  assign refuse   = isCfg & (isWrite | ~cfgImpl);
  assign memEn    = accept & ~refuse;
  assign memWe    = memEn & isWrite;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (reqValid) stateD = ST_WAIT;
      ST_WAIT: stateD = ST_RESP;
      ST_RESP: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      errQ    <= 1'b0;
      noDataQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) begin
        errQ    <= refuse;
        noDataQ <= refuse | isWrite;
      end
    end
  end

  assign strobe.latch    = accept;
  assign strobe.capture  = (stateQ == ST_WAIT);
  assign strobe.zeroData = noDataQ;
  assign rspValid        = (stateQ == ST_RESP);
  assign rspErr          = rspValid & errQ;
endmodule

// File: rtl/pta_datapath.sv
module pta_datapath
  import pta_pkg::*;
#(
  parameter int PAGE_W         = 8,
  parameter int EA_W           = 16,
  parameter int CFG_IMPL_WORDS = 64,
  localparam int ADDR_W        = PAGE_W - 1 + EA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageWe,
  input  logic [PAGE_W-1:0] pageWdata,
  input  tblOp_e            reqOp,
  input  logic              reqByte,
  input  logic [EA_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  tblStrobe_t        strobe,
  input  logic [WORD_W-1:0] memRdata,
  output logic              isCfg,
  output logic              cfgImpl,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCfg,
  output logic [LANES-1:0]  memWmask,
  output logic [WORD_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspRdata
);
  logic [PAGE_W-1:0] pageQ;
  logic              opHiQ, byteQ, bselQ;
  logic [DATA_W-1:0] rdataQ, fmtData;
  logic              bsel;

  assign bsel    = reqAddr[0];
  assign memAddr = {pageQ[PAGE_W-2:0], reqAddr[EA_W-1:1]};
  assign memCfg  = pageQ[PAGE_W-1];
  assign isCfg   = memCfg;
  assign cfgImpl = (memAddr < ADDR_W'(CFG_IMPL_WORDS));

  // Lane placement for writes
  always_comb begin
    memWmask = '0;
    memWdata = '0;
    unique case (reqOp)
      OP_WR_LO: begin
        if (!reqByte) begin
          memWmask                 = 3'b011;
          memWdata[DATA_W-1:0]     = reqWdata;
        end else if (bsel) begin
          memWmask                 = 3'b010;
          memWdata[2*LANE_W-1:LANE_W] = reqWdata[LANE_W-1:0];
        end else begin
          memWmask                 = 3'b001;
          memWdata[LANE_W-1:0]     = reqWdata[LANE_W-1:0];
        end
      end
      OP_WR_HI: begin
        if (!reqByte || !bsel) begin
          memWmask                 = 3'b100;
          memWdata[WORD_W-1:DATA_W] = reqWdata[LANE_W-1:0];
        end
      end
      default: ;
    endcase
  end

  // Lane selection and zero fill for reads
  always_comb begin
    fmtData = '0;
    if (!opHiQ) begin
      if (!byteQ) fmtData = memRdata[DATA_W-1:0];
      else if (bselQ) fmtData[LANE_W-1:0] = memRdata[2*LANE_W-1:LANE_W];
      else fmtData[LANE_W-1:0] = memRdata[LANE_W-1:0];
    end else if (!(byteQ && bselQ)) begin
      fmtData[LANE_W-1:0] = memRdata[WORD_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ  <= '0;
      opHiQ  <= 1'b0;
      byteQ  <= 1'b0;
      bselQ  <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (pageWe) pageQ <= pageWdata;
      if (strobe.latch) begin
        opHiQ <= reqOp[0];
        byteQ <= reqByte;
        bselQ <= bsel;
      end
      if (strobe.capture) rdataQ <= strobe.zeroData ? '0 : fmtData;
    end
  end

  assign rspRdata = rdataQ;
endmodule

// File: rtl/pgm_table_access.sv
module pgm_table_access
  import pta_pkg::*;
#(
  parameter int PAGE_W         = 8,
  parameter int EA_W           = 16,
  parameter int CFG_IMPL_WORDS = 64,
  localparam int ADDR_W        = PAGE_W - 1 + EA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageWe,
  input  logic [PAGE_W-1:0] pageWdata,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic              reqByte,
  input  logic [EA_W-1:0]   reqAddr,
  input  logic [15:0]       reqWdata,
  output logic              rspValid,
  output logic [15:0]       rspRdata,
  output logic              rspErr,
  output logic              memEn,
  output logic              memWe,
  output logic              memCfg,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        memWmask,
  output logic [23:0]       memWdata,
  input  logic [23:0]       memRdata
);
  tblStrobe_t strobe;
  logic       isCfg, cfgImpl;

  pta_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .isWrite  (reqOp[1]),
    .isCfg    (isCfg),
    .cfgImpl  (cfgImpl),
    .reqReady (reqReady),
    .memEn    (memEn),
    .memWe    (memWe),
    .strobe   (strobe),
    .rspValid (rspValid),
    .rspErr   (rspErr)
  );

  pta_datapath #(
    .PAGE_W         (PAGE_W),
    .EA_W           (EA_W),
    .CFG_IMPL_WORDS (CFG_IMPL_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pageWe    (pageWe),
    .pageWdata (pageWdata),
    .reqOp     (tblOp_e'(reqOp)),
    .reqByte   (reqByte),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .strobe    (strobe),
    .memRdata  (memRdata),
    .isCfg     (isCfg),
    .cfgImpl   (cfgImpl),
    .memAddr   (memAddr),
    .memCfg    (memCfg),
    .memWmask  (memWmask),
    .memWdata  (memWdata),
    .rspRdata  (rspRdata)
  );
endmodule

// File: rtl/pgm_table_access_chk.sv
module pgm_table_access_chk #(
  parameter int ADDR_W         = 22,
  parameter int CFG_IMPL_WORDS = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqOp,
  input logic              rspValid,
  input logic [15:0]       rspRdata,
  input logic              rspErr,
  input logic              memEn,
  input logic              memWe,
  input logic              memCfg,
  input logic [ADDR_W-1:0] memAddr
);
  logic hiQ;

  always_ff @(posedge clk) begin
    if (!rstN) hiQ <= 1'b0;
    else if (reqValid && reqReady) hiQ <= reqOp[0];
  end

  AST_CFG_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !memCfg); // R8
  AST_CFG_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memCfg) |-> (memAddr < ADDR_W'(CFG_IMPL_WORDS))); // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspRdata == 16'h0)); // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |=> !rspErr); // R9
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ##1 rspValid); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady); // R10
  AST_MEM_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (reqValid && reqReady)); // R10
  AST_HIGH_PHANTOM: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && hiQ) |-> (rspRdata[15:8] == 8'h0)); // R4
endmodule

bind pgm_table_access pgm_table_access_chk #(
  .ADDR_W         (ADDR_W),
  .CFG_IMPL_WORDS (CFG_IMPL_WORDS)
) u_chk (.*);

// File: tb/sim_pgm_table_access.sv
`timescale 1ns/1ps
module sim_pgm_table_access;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pageWe = 1'b0;
  logic [7:0]  pageWdata = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = '0;
  logic        reqByte = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [15:0] rspRdata;
  logic        rspErr;
  logic        memEn, memWe, memCfg;
  logic [21:0] memAddr;
  logic [2:0]  memWmask;
  logic [23:0] memWdata;
  logic [23:0] memRdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] tbPage = 8'h00;

  logic [23:0] memStore [int];
  logic [23:0] refStore [int];
  int          dueQ [$];
  logic [15:0] datQ [$];
  logic        errQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  pgm_table_access u0 (.*);

  function automatic logic [23:0] dflt(int k);
    return 24'((k * 40503) ^ 24'hA53C96);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory with one-cycle read latency
  always @(posedge clk) begin
    int k;
    logic [23:0] w;
    if (memEn) begin
      k = int'({memCfg, memAddr});
      w = memStore.exists(k) ? memStore[k] : dflt(k);
      if (memWe) begin
        for (int l = 0; l < 3; l++)
          if (memWmask[l]) w[l*8 +: 8] = memWdata[l*8 +: 8];
        memStore[k] = w;
      end else begin
        memRdata <= w;
      end
    end
  end

  // Reference model, compared every cycle
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (dueQ.size() > 0 && dueQ[0] == cyc) begin
        int d;
        logic [15:0] ed;
        logic ee;
        string tg;
        d = dueQ.pop_front(); ed = datQ.pop_front(); ee = errQ.pop_front(); tg = tagQ.pop_front();
        chk(rspValid === 1'b1, "R10", "rspValid at due cycle", rspValid, 1);
        chk(rspErr === ee, tg, "rspErr", rspErr, ee);
        chk(rspRdata === ed, tg, "rspRdata", rspRdata, ed);
      end else begin
        chk(rspValid === 1'b0, "R10", "rspValid outside due cycle", rspValid, 0);
      end
      if (reqValid && reqReady) begin
        logic cfg, bsel, wr, hi, refused;
        logic [21:0] a;
        logic [23:0] w;
        logic [2:0] em;
        logic [23:0] ew;
        logic [15:0] ed;
        int k;
        string tg;
        cfg = tbPage[7];
        a = {tbPage[6:0], reqAddr[15:1]};
        bsel = reqAddr[0];
        wr = reqOp[1];
        hi = reqOp[0];
        refused = cfg && (wr || a >= 22'd64);
        k = int'({cfg, a});
        w = refStore.exists(k) ? refStore[k] : dflt(k);
        chk(memEn === !refused, wr ? "R8" : "R9", "memEn", memEn, !refused);
        if (!refused) begin
          chk(memAddr === a, "R1", "memAddr", memAddr, a);
          chk(memCfg === cfg, "R1", "memCfg", memCfg, cfg);
          chk(memWe === wr, "R10", "memWe", memWe, wr);
        end
        ed = 16'h0;
        if (refused) tg = wr ? "R8" : "R9";
        else if (wr) begin
          em = 3'b000; ew = 24'h0;
          if (!hi) begin
            tg = "R6";
            if (!reqByte) begin em = 3'b011; ew[15:0] = reqWdata; end
            else if (bsel) begin em = 3'b010; ew[15:8] = reqWdata[7:0]; end
            else begin em = 3'b001; ew[7:0] = reqWdata[7:0]; end
          end else begin
            tg = "R7";
            if (!(reqByte && bsel)) begin em = 3'b100; ew[23:16] = reqWdata[7:0]; end
          end
          chk(memWmask === em, tg, "memWmask", memWmask, em);
          for (int l = 0; l < 3; l++)
            if (em[l]) begin
              chk(memWdata[l*8 +: 8] === ew[l*8 +: 8], tg, "memWdata lane", memWdata[l*8 +: 8], ew[l*8 +: 8]);
              w[l*8 +: 8] = ew[l*8 +: 8];
            end
          refStore[k] = w;
        end else if (!hi) begin
          tg = reqByte ? "R3" : "R2";
          if (!reqByte) ed = w[15:0];
          else ed = {8'h0, bsel ? w[15:8] : w[7:0]};
        end else begin
          tg = reqByte ? "R5" : "R4";
          ed = (reqByte && bsel) ? 16'h0 : {8'h0, w[23:16]};
        end
        dueQ.push_back(cyc + 2);
        datQ.push_back(ed);
        errQ.push_back(refused);
        tagQ.push_back(tg);
      end
    end
  end

  task automatic setPage(logic [7:0] p);
    @(posedge clk); #1;
    pageWe = 1'b1; pageWdata = p;
    @(posedge clk); #1;
    pageWe = 1'b0;
    tbPage = p;
  endtask

  task automatic access(logic [1:0] op, logic byteM, logic [15:0] ea, logic [15:0] wd);
    @(posedge clk); #1;
    while (!reqReady) begin @(posedge clk); #1; end
    reqValid = 1'b1; reqOp = op; reqByte = byteM; reqAddr = ea; reqWdata = wd;
    @(posedge clk); #1;
    reqValid = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R11 / R10: reset state
    chk(reqReady === 1'b1, "R10", "reqReady after reset", reqReady, 1);
    chk(rspValid === 1'b0, "R11", "rspValid after reset", rspValid, 0);
    chk(rspErr === 1'b0, "R11", "rspErr after reset", rspErr, 0);
    chk(memEn === 1'b0, "R11", "memEn after reset", memEn, 0);
    // R11: page 0 at reset, user memory
    access(2'd0, 1'b0, 16'h0010, 16'h0);
    // R2 R3 R4 R5 reads
    access(2'd0, 1'b1, 16'h0011, 16'h0);
    access(2'd0, 1'b1, 16'h0010, 16'h0);
    access(2'd1, 1'b0, 16'h0011, 16'h0);
    access(2'd1, 1'b1, 16'h0010, 16'h0);
    access(2'd1, 1'b1, 16'h0011, 16'h0);
    // R6 R7 writes and readback
    access(2'd2, 1'b0, 16'h0020, 16'hBEEF);
    access(2'd2, 1'b1, 16'h0021, 16'hFF12);
    access(2'd2, 1'b1, 16'h0020, 16'hFF34);
    access(2'd3, 1'b0, 16'h0022, 16'hAB77);
    access(2'd3, 1'b1, 16'h0023, 16'h0099);
    access(2'd3, 1'b1, 16'h0022, 16'h0055);
    access(2'd0, 1'b0, 16'h0020, 16'h0);
    access(2'd1, 1'b0, 16'h0020, 16'h0);
    access(2'd1, 1'b0, 16'h0022, 16'h0);
    access(2'd1, 1'b1, 16'h0023, 16'h0);
    // R1 another user page
    setPage(8'h05);
    access(2'd2, 1'b0, 16'hFFFE, 16'h1234);
    access(2'd0, 1'b0, 16'hFFFE, 16'h0);
    // R8 R9 configuration region
    setPage(8'h80);
    access(2'd0, 1'b0, 16'h0004, 16'h0);
    access(2'd1, 1'b0, 16'h007E, 16'h0);
    access(2'd0, 1'b0, 16'h0080, 16'h0);
    access(2'd2, 1'b0, 16'h0004, 16'hDEAD);
    access(2'd3, 1'b1, 16'h0004, 16'h00AA);
    access(2'd0, 1'b0, 16'h0004, 16'h0);
    access(2'd1, 1'b0, 16'h0004, 16'h0);
    setPage(8'h81);
    access(2'd0, 1'b0, 16'h0000, 16'h0);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [15:0] ea;
      sel = int'($urandom % 5);
      if (i % 8 == 0) begin
        case (sel)
          0: setPage(8'h00);
          1: setPage(8'h03);
          2: setPage(8'h7F);
          3: setPage(8'h80);
          default: setPage(8'h81);
        endcase
      end
      ea = (($urandom % 2) == 0) ? 16'($urandom % 160) : 16'($urandom);
      access(2'($urandom), 1'($urandom), ea, 16'($urandom));
    end
    repeat (4) @(posedge clk);
    chk(dueQ.size() == 0, "R10", "responses outstanding", dueQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule